// File: doc/BRIEF.md
# Bit Shift and Rotate Execution Unit

This unit executes one shift or rotate on an operand of 8, 16 or 32 bits and returns the result with updated condition flags. A caller presents the operand, a size code, a shift count, an operation code and the current flag values (carry, overflow, zero, sign, parity) together with a one-cycle valid strobe. One clock edge later the unit presents the result and the new flags, marked by a one-cycle done pulse. The outputs then hold until the next strobe.

Seven operations are supported: three shifts (logical left, logical right, arithmetic right) and four rotates (plain left, plain right, and left and right through carry). A multi-bit count always gives the same result as that many single-bit steps, including counts that exceed the operand width. Flags that an operation must not alter are passed through from the flag inputs. This lets the unit sit directly in an integer pipeline between the flag register read and write-back.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 0 (logical left) shifts zeros into bit 0. Carry becomes the last bit shifted out of the top of the selected size, which is 0 once the count exceeds the size.
- R2: Code 1 (logical right) fills the top with zeros. Code 2 (arithmetic right) fills it with copies of the old top bit. Both put the last bit shifted out of bit 0 into carry. Arithmetic right of 16-bit 0xFFF1 (-15) by one gives 0xFFF8 (-8) with carry 1.
- R3: Code 3 (rotate left) moves the old top bit into bit 0, and carry ends equal to the new bit 0. Code 4 (rotate right) moves bit 0 into the top bit, and carry ends equal to the new top bit.
- R4: Codes 5 and 6 (rotate left/right through carry) rotate the operand and the carry together as a ring of size+1 bits. A count of size+1 returns both the operand and the carry to their starting values.
- R5: With a count of exactly one, overflow is set as follows. Left shift, left rotate and left rotate through carry: new top bit XOR new carry. Logical right: the old top bit. Arithmetic right: 0. Rotate right: XOR of the two highest result bits. Rotate right through carry: old top bit XOR old carry. For any count above one, overflow is driven 0.
- R6: After a shift with a nonzero count, zero is set when the result is all zeros and sign equals the result's top bit. Parity is 1 when the low 8 result bits hold an even number of ones.
- R7: All four rotates leave the zero, sign and parity outputs equal to their inputs.
- R8: Only the low 5 bits of the count are used. When they are zero, or the operation code is 7, the result equals the size-masked operand and every flag output equals its input.
- R9: Size code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 32 bits. Operand bits above the selected size are ignored, and result bits above it are 0.
- R10: A valid strobe at a clock edge makes the result and flags appear after that edge, with done high for exactly one cycle. Without a strobe, done is low and the outputs hold.
- R11: During reset, done, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe |
| in_op | input | 3 | Operation code (0..7) |
| in_size | input | 2 | Operand size code |
| in_data | input | 32 | Operand |
| in_count | input | 8 | Shift count (low 5 bits used) |
| in_cf | input | 1 | Incoming carry |
| in_of | input | 1 | Incoming overflow |
| in_zf | input | 1 | Incoming zero flag |
| in_sf | input | 1 | Incoming sign flag |
| in_pf | input | 1 | Incoming parity flag |
| out_done | output | 1 | Result valid pulse |
| out_data | output | 32 | Result |
| out_cf | output | 1 | Carry out |
| out_of | output | 1 | Overflow out |
| out_zf | output | 1 | Zero flag out |
| out_sf | output | 1 | Sign flag out |
| out_pf | output | 1 | Parity flag out |

## Verification
Directed cases use sign-bit patterns (0x80, 0xFFF1, 0x40000000) to separate arithmetic from logical right shifts and to expose overflow on single-bit steps. Counts of 1, 3, the full width, width+1 and 32 distinguish the single-step flag rules, the all-out shift results, the ring closure of rotate-through-carry and count masking. Operands with garbage above the selected size show that the size mask is applied. A long pseudo-random sweep over every operation, size and count is compared against a step-by-step model, which catches errors in the closed-form shifter at every count.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

   typedef enum logic [2:0] {
      OP_SHL  = 3'd0,
      OP_SHR  = 3'd1,
      OP_SAR  = 3'd2,
      OP_ROL  = 3'd3,
      OP_ROR  = 3'd4,
      OP_RCL  = 3'd5,
      OP_RCR  = 3'd6,
      OP_PASS = 3'd7
   } shrot_op_e;

   typedef struct packed {
      logic cf;
      logic of;
      logic zf;
      logic sf;
      logic pf;
   } shrot_flags_t;

   function automatic logic is_rotate(shrot_op_e op);
      return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
   endfunction

endpackage

// File: rtl/shrot_shift_path.sv
module shrot_shift_path
   import shrot_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 5,
   localparam int NB_W  = $clog2(DATA_W) + 1,
   localparam int MI_W  = $clog2(DATA_W)
) (
   input  shrot_op_e         op,
   input  logic [NB_W-1:0]   n_bits,
   input  logic [MI_W-1:0]   msb_idx,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] data,
   input  logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] res,
   output logic              cf_out,
   output logic              of_one
);

   logic [DATA_W:0]        t_left;
   logic [DATA_W:0]        t_right;
   logic signed [DATA_W:0] t_arith;
   logic [DATA_W-1:0]      data_se;
   logic                   old_top;

   assign old_top = data[msb_idx];
   assign data_se = data | (old_top ? ~mask : '0);

   // one extra bit below / above the operand keeps the last bit shifted out
   assign t_left  = {1'b0, data} << cnt;
   assign t_right = {data, 1'b0} >> cnt;
   assign t_arith = $signed({data_se, 1'b0}) >>> cnt;

   always_comb begin
      res    = '0;
      cf_out = 1'b0;
      of_one = 1'b0;
      unique case (op)
         OP_SHL: begin
            res    = t_left[DATA_W-1:0] & mask;
            cf_out = t_left[n_bits];
            of_one = res[msb_idx] ^ cf_out;
         end
         OP_SHR: begin
            res    = t_right[DATA_W:1];
            cf_out = t_right[0];
            of_one = old_top;
         end
         OP_SAR: begin
            res    = t_arith[DATA_W:1] & mask;
            cf_out = t_arith[0];
            of_one = 1'b0;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/shrot_rot_path.sv
module shrot_rot_path
   import shrot_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 5,
   parameter int MIN_W  = 8,
   localparam int NB_W  = $clog2(DATA_W) + 1,
   localparam int MI_W  = $clog2(DATA_W),
   localparam int RW    = DATA_W + 1,
   localparam int MOD_ITER = (2**CNT_W) / (MIN_W + 1) + 1
) (
   input  shrot_op_e         op,
   input  logic [NB_W-1:0]   n_bits,
   input  logic [MI_W-1:0]   msb_idx,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] data,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              cf_in,
   output logic [DATA_W-1:0] res,
   output logic              cf_out,
   output logic              of_one
);

   logic [CNT_W-1:0]  r_plain;
   logic [NB_W:0]     r_ring;
   logic [NB_W:0]     ring_len;
   logic [RW-1:0]     ring;
   logic [RW-1:0]     ring_mask;
   logic [RW-1:0]     ring_l;
   logic [RW-1:0]     ring_r;
   logic [DATA_W-1:0] rot_l;
   logic [DATA_W-1:0] rot_r;

   // plain rotate: count modulo the size (power of two)
   assign r_plain = cnt & CNT_W'(n_bits - 1'b1);
   assign rot_l   = ((data << r_plain) | (data >> (n_bits - r_plain))) & mask;
   assign rot_r   = ((data >> r_plain) | (data << (n_bits - r_plain))) & mask;

   // carry ring: operand in bits n-1..0, carry in bit n
   assign ring_len  = {1'b0, n_bits} + (NB_W+1)'(1);
   assign ring      = {1'b0, data} | (RW'(cf_in) << n_bits);
   assign ring_mask = {RW{1'b1}} >> (RW - ring_len);

   always_comb begin
      r_ring = (NB_W+1)'(cnt);
      for (int k = 0; k < MOD_ITER; k++) begin
         if (r_ring >= ring_len) r_ring = r_ring - ring_len;
      end
   end

   assign ring_l = ((ring << r_ring) | (ring >> (ring_len - r_ring))) & ring_mask;
   assign ring_r = ((ring >> r_ring) | (ring << (ring_len - r_ring))) & ring_mask;

   always_comb begin
      res    = '0;
      cf_out = 1'b0;
      of_one = 1'b0;
      unique case (op)
         OP_ROL: begin
            res    = rot_l;
            cf_out = rot_l[0];
            of_one = rot_l[msb_idx] ^ rot_l[0];
         end
         OP_ROR: begin
            res    = rot_r;
            cf_out = rot_r[msb_idx];
            of_one = rot_r[msb_idx] ^ rot_r[msb_idx - 1'b1];
         end
         OP_RCL: begin
            res    = ring_l[DATA_W-1:0] & mask;
            cf_out = ring_l[n_bits];
            of_one = res[msb_idx] ^ cf_out;
         end
         OP_RCR: begin
            res    = ring_r[DATA_W-1:0] & mask;
            cf_out = ring_r[n_bits];
            of_one = data[msb_idx] ^ cf_in;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 5,
   parameter int CNT_IN_W = 8,
   parameter int PAR_W    = 8,
   localparam int NB_W    = $clog2(DATA_W) + 1,
   localparam int MI_W    = $clog2(DATA_W)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [2:0]          in_op,
   input  logic [1:0]          in_size,
   input  logic [DATA_W-1:0]   in_data,
   input  logic [CNT_IN_W-1:0] in_count,
   input  logic                in_cf,
   input  logic                in_of,
   input  logic                in_zf,
   input  logic                in_sf,
   input  logic                in_pf,
   output logic                out_done,
   output logic [DATA_W-1:0]   out_data,
   output logic                out_cf,
   output logic                out_of,
   output logic                out_zf,
   output logic                out_sf,
   output logic                out_pf
);

   generate
      if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0)
         $error("shrot_unit: DATA_W must be a power of two of at least 16");
      if (CNT_W > NB_W || CNT_IN_W < CNT_W)
         $error("shrot_unit: count widths inconsistent with DATA_W");
      if (PAR_W > 8 || PAR_W < 1)
         $error("shrot_unit: PAR_W must be 1..8");
   endgenerate

   shrot_op_e         op_e;
   logic [NB_W-1:0]   n_bits;
   logic [MI_W-1:0]   msb_idx;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] data_m;
   logic [CNT_W-1:0]  cnt;
   logic              unused_cnt_hi;
   shrot_flags_t      flags_in;

   assign op_e          = shrot_op_e'(in_op);
   assign cnt           = in_count[CNT_W-1:0];
   assign unused_cnt_hi = ^in_count;
   assign flags_in      = '{cf: in_cf, of: in_of, zf: in_zf, sf: in_sf, pf: in_pf};

   always_comb begin
      unique case (in_size)
         2'd0:    n_bits = NB_W'(8);
         2'd1:    n_bits = NB_W'(16);
         default: n_bits = NB_W'(DATA_W);
      endcase
   end

   assign msb_idx = MI_W'(n_bits - 1'b1);
   assign mask    = {DATA_W{1'b1}} >> (DATA_W - n_bits);
   assign data_m  = in_data & mask;

   logic [DATA_W-1:0] sh_res, rt_res;
   logic              sh_cf, sh_of1, rt_cf, rt_of1;

   shrot_shift_path #(.DATA_W(DATA_W), .CNT_W(CNT_W)) shift_i (
      .op(op_e), .n_bits(n_bits), .msb_idx(msb_idx), .mask(mask),
      .data(data_m), .cnt(cnt), .res(sh_res), .cf_out(sh_cf), .of_one(sh_of1)
   );

   shrot_rot_path #(.DATA_W(DATA_W), .CNT_W(CNT_W)) rot_i (
      .op(op_e), .n_bits(n_bits), .msb_idx(msb_idx), .mask(mask),
      .data(data_m), .cnt(cnt), .cf_in(in_cf),
      .res(rt_res), .cf_out(rt_cf), .of_one(rt_of1)
   );

   // even-parity chain over the low result byte
   logic [DATA_W-1:0] nxt_res;
   logic [PAR_W:0]    par_chain;
   assign par_chain[0] = 1'b1;
   generate
      for (genvar g = 0; g < PAR_W; g++) begin : g_par
         assign par_chain[g+1] = par_chain[g] ^ nxt_res[g];
      end
   endgenerate

   shrot_flags_t nxt_flags;
   logic         single;
   assign single = (cnt == CNT_W'(1));

   always_comb begin
      nxt_res   = data_m;
      nxt_flags = flags_in;
      if (cnt != '0 && op_e != OP_PASS) begin
         if (is_rotate(op_e)) begin
            nxt_res      = rt_res;
            nxt_flags.cf = rt_cf;
            nxt_flags.of = single ? rt_of1 : 1'b0;
         end else begin
            nxt_res      = sh_res;
            nxt_flags.cf = sh_cf;
            nxt_flags.of = single ? sh_of1 : 1'b0;
            nxt_flags.zf = (sh_res == '0);
            nxt_flags.sf = sh_res[msb_idx];
            nxt_flags.pf = par_chain[PAR_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_done <= 1'b0;
         out_data <= '0;
         {out_cf, out_of, out_zf, out_sf, out_pf} <= '0;
      end else begin
         out_done <= in_valid;
         if (in_valid) begin
            out_data <= nxt_res;
            {out_cf, out_of, out_zf, out_sf, out_pf} <= nxt_flags;
         end
      end
   end

   // ---------------- assertions ----------------
   a_r10_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_done);
   a_r10_no_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_done);
   a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data) && $stable(out_cf));
   a_r8_zero_count_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cnt == '0) |=> (out_data == $past(data_m)) &&
      ({out_cf, out_of, out_zf, out_sf, out_pf} == $past(flags_in)));
   a_r7_rotate_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && is_rotate(op_e)) |=>
      (out_zf == $past(in_zf)) && (out_sf == $past(in_sf)) && (out_pf == $past(in_pf)));
   a_r9_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_size == 2'd0) |=> (out_data[DATA_W-1:8] == '0));
   a_r5_multi_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cnt > CNT_W'(1) && op_e != OP_PASS) |=> !out_of);
   a_r1_shl_one_carry: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_e == OP_SHL && single) |=> (out_cf == $past(data_m[msb_idx])));

endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_op = '0;
   logic [1:0]  in_size = '0;
   logic [31:0] in_data = '0;
   logic [7:0]  in_count = '0;
   logic        in_cf = 1'b0, in_of = 1'b0, in_zf = 1'b0, in_sf = 1'b0, in_pf = 1'b0;
   logic        out_done;
   logic [31:0] out_data;
   logic        out_cf, out_of, out_zf, out_sf, out_pf;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   shrot_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_size(in_size),
      .in_data(in_data), .in_count(in_count), .in_cf(in_cf), .in_of(in_of),
      .in_zf(in_zf), .in_sf(in_sf), .in_pf(in_pf), .out_done(out_done),
      .out_data(out_data), .out_cf(out_cf), .out_of(out_of), .out_zf(out_zf),
      .out_sf(out_sf), .out_pf(out_pf)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // step-by-step reference; flags packed {cf,of,zf,sf,pf}
   function automatic void ref_model(input int op, input int size, input logic [31:0] d,
                                     input logic [7:0] cin, input logic [4:0] fin,
                                     output logic [31:0] r, output logic [4:0] fout);
      int          n;
      int          c;
      logic [31:0] mask, v, t;
      logic        cf, oldtop, oldcf, of, zf, sf, pf;
      n    = (size == 0) ? 8 : (size == 1) ? 16 : 32;
      mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
      v    = d & mask;
      c    = int'(cin & 8'h1F);
      fout = fin;
      r    = v;
      if (c == 0 || op == 7) return;
      cf = fin[4]; oldtop = v[n-1]; oldcf = fin[4];
      for (int k = 0; k < c; k++) begin
         case (op)
            0: begin cf = v[n-1]; v = (v << 1) & mask; end
            1: begin cf = v[0]; v = v >> 1; end
            2: begin t = 32'(v[n-1]); cf = v[0]; v = (v >> 1) | (t << (n-1)); end
            3: begin t = 32'(v[n-1]); v = ((v << 1) | t) & mask; cf = t[0]; end
            4: begin t = 32'(v[0]); v = (v >> 1) | (t << (n-1)); cf = t[0]; end
            5: begin t = 32'(v[n-1]); v = ((v << 1) | 32'(cf)) & mask; cf = t[0]; end
            default: begin t = 32'(v[0]); v = (v >> 1) | (32'(cf) << (n-1)); cf = t[0]; end
         endcase
      end
      of = 1'b0;
      if (c == 1) begin
         case (op)
            0, 3, 5: of = v[n-1] ^ cf;
            1:       of = oldtop;
            2:       of = 1'b0;
            4:       of = v[n-1] ^ v[n-2];
            default: of = oldtop ^ oldcf;
         endcase
      end
      zf = fin[2]; sf = fin[1]; pf = fin[0];
      if (op <= 2) begin
         zf = (v == 0);
         sf = v[n-1];
         pf = ~^v[7:0];
      end
      r    = v;
      fout = {cf, of, zf, sf, pf};
   endfunction

   // drive one operation, sample one cycle after capture, compare all outputs
   task automatic run(input string tag, input int op, input int size, input logic [31:0] d,
                      input logic [7:0] cnt, input logic [4:0] fin);
      logic [31:0] er;
      logic [4:0]  ef;
      ref_model(op, size, d, cnt, fin, er, ef);
      @(negedge clk);
      in_valid = 1'b1; in_op = 3'(op); in_size = 2'(size); in_data = d; in_count = cnt;
      {in_cf, in_of, in_zf, in_sf, in_pf} = fin;
      @(negedge clk);
      in_valid = 1'b0;
      chk(tag, "done", 32'(out_done), 32'd1);
      chk(tag, "data", out_data, er);
      chk(tag, "flags", 32'({out_cf, out_of, out_zf, out_sf, out_pf}), 32'(ef));
   endtask

   task automatic t_reset();
      chk("R11", "done", 32'(out_done), 0);
      chk("R11", "data", out_data, 0);
      chk("R11", "flags", 32'({out_cf, out_of, out_zf, out_sf, out_pf}), 0);
   endtask

   task automatic t_shl();
      run("R1", 0, 0, 32'h0000_00C3, 8'd1, 5'b00000);
      chk("R1", "shl 0xC3<<1 byte", out_data, 32'h86);
      chk("R1", "shl carry", 32'(out_cf), 1);
      run("R1", 0, 1, 32'h0000_8001, 8'd4, 5'b00000);
      run("R1", 0, 0, 32'h0000_00FF, 8'd9, 5'b10000);
      chk("R1", "shl past width carry", 32'(out_cf), 0);
      run("R1", 0, 2, 32'h8000_0001, 8'd31, 5'b00000);
   endtask

   task automatic t_right();
      run("R2", 2, 1, 32'h0000_FFF1, 8'd1, 5'b00000);
      chk("R2", "sar -15 by 1", out_data, 32'h0000_FFF8);
      chk("R2", "sar carry", 32'(out_cf), 1);
      run("R2", 1, 1, 32'h0000_FFFF, 8'd1, 5'b00000);
      chk("R2", "shr 0xFFFF by 1", out_data, 32'h0000_7FFF);
      run("R2", 2, 0, 32'h0000_0080, 8'd7, 5'b00000);
      chk("R2", "sar fills sign", out_data, 32'h0000_00FF);
      run("R2", 1, 2, 32'hF000_0000, 8'd28, 5'b00000);
      run("R2", 2, 2, 32'h4000_0000, 8'd20, 5'b00000);
   endtask

   task automatic t_rot();
      run("R3", 3, 0, 32'h0000_0081, 8'd1, 5'b00000);
      chk("R3", "rol 0x81", out_data, 32'h03);
      run("R3", 4, 0, 32'h0000_0001, 8'd1, 5'b00000);
      chk("R3", "ror 0x01", out_data, 32'h80);
      chk("R3", "ror carry", 32'(out_cf), 1);
      run("R3", 3, 1, 32'h0000_1234, 8'd16, 5'b00000);
      chk("R3", "rol full width", out_data, 32'h1234);
      run("R3", 4, 2, 32'h1234_5678, 8'd12, 5'b00000);
   endtask

   task automatic t_ring();
      run("R4", 5, 0, 32'h0000_00A5, 8'd9, 5'b10000);
      chk("R4", "rcl 9 restores data", out_data, 32'hA5);
      chk("R4", "rcl 9 restores carry", 32'(out_cf), 1);
      run("R4", 6, 1, 32'h0000_8421, 8'd17, 5'b00000);
      chk("R4", "rcr 17 restores data", out_data, 32'h8421);
      run("R4", 5, 0, 32'h0000_0080, 8'd1, 5'b00000);
      chk("R4", "rcl top into carry", 32'(out_cf), 1);
      run("R4", 6, 2, 32'h0000_0001, 8'd1, 5'b10000);
      chk("R4", "rcr carry into top", out_data, 32'h8000_0000);
      run("R4", 6, 0, 32'h0000_005A, 8'd13, 5'b10000);
   endtask

   task automatic t_of();
      run("R5", 0, 0, 32'h0000_0040, 8'd1, 5'b00000);
      chk("R5", "shl sign change of", 32'(out_of), 1);
      run("R5", 1, 0, 32'h0000_0080, 8'd1, 5'b00000);
      chk("R5", "shr old top of", 32'(out_of), 1);
      run("R5", 6, 0, 32'h0000_0000, 8'd1, 5'b10000);
      chk("R5", "rcr old top xor carry", 32'(out_of), 1);
      run("R5", 0, 0, 32'h0000_0040, 8'd3, 5'b01000);
      chk("R5", "multi count of zero", 32'(out_of), 0);
   endtask

   task automatic t_flags();
      run("R6", 1, 0, 32'h0000_0001, 8'd1, 5'b00000);
      chk("R6", "zero flag", 32'(out_zf), 1);
      run("R6", 0, 1, 32'h0000_0300, 8'd1, 5'b00000);
      chk("R6", "parity low byte", 32'(out_pf), 1);
      run("R6", 2, 1, 32'h0000_8007, 8'd1, 5'b00111);
      chk("R6", "sign flag", 32'(out_sf), 1);
   endtask

   task automatic t_rot_keep();
      run("R7", 3, 0, 32'h0000_0000, 8'd3, 5'b00101);
      chk("R7", "rol keeps zf/sf/pf", 32'({out_zf, out_sf, out_pf}), 32'b101);
      run("R7", 6, 1, 32'h0000_FFFF, 8'd5, 5'b00010);
      chk("R7", "rcr keeps zf/sf/pf", 32'({out_zf, out_sf, out_pf}), 32'b010);
   endtask

   task automatic t_count_mask();
      run("R8", 0, 0, 32'h0000_0055, 8'd32, 5'b11010);
      chk("R8", "count 32 masked to 0", out_data, 32'h55);
      chk("R8", "flags preserved", 32'({out_cf, out_of, out_zf, out_sf, out_pf}), 32'b11010);
      run("R8", 7, 1, 32'hFFFF_1234, 8'd3, 5'b01101);
      chk("R8", "pass op", out_data, 32'h1234);
      run("R8", 2, 0, 32'h0000_0080, 8'd33, 5'b00000);
      chk("R8", "count 33 acts as 1", out_data, 32'hC0);
   endtask

   task automatic t_size();
      run("R9", 1, 0, 32'hABCD_EF10, 8'd4, 5'b00000);
      chk("R9", "byte ignores upper", out_data, 32'h01);
      run("R9", 0, 3, 32'h0000_0001, 8'd31, 5'b00000);
      chk("R9", "code 3 is 32 bits", out_data, 32'h8000_0000);
      run("R9", 3, 1, 32'hFFFF_8000, 8'd1, 5'b00000);
      chk("R9", "word rotate", out_data, 32'h0001);
   endtask

   task automatic t_timing();
      logic [31:0] held;
      run("R10", 0, 2, 32'h0000_0101, 8'd2, 5'b00000);
      held = out_data;
      @(negedge clk);
      chk("R10", "done one cycle", 32'(out_done), 0);
      in_data = 32'hFFFF_FFFF; in_count = 8'd5;
      @(negedge clk);
      chk("R10", "result holds", out_data, held);
   endtask

   task automatic t_sweep();
      logic [31:0] lfsr = 32'hACE1_2468;
      string tags [8] = '{"R1", "R2", "R2", "R3", "R3", "R4", "R4", "R8"};
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         run(tags[i % 8], i % 8, (i / 8) % 4, lfsr ^ {lfsr[15:0], lfsr[31:16]},
             8'(lfsr[12:5]), 5'(lfsr[27:23]));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_shl();
      t_right();
      t_rot();
      t_ring();
      t_of();
      t_flags();
      t_rot_keep();
      t_count_mask();
      t_size();
      t_timing();
      t_sweep();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule